// File: doc/BRIEF.md
# Program Counter and Return Stack

This block produces the fetch address for a small core whose instructions are 12 bits wide. It holds a 9-bit program counter and a return stack with two levels. The block takes one step per instruction cycle, on each cycle where the advance strobe is high. At each step it either moves to the next word or takes one of four kinds of branch: a jump, a subroutine call, a return with literal, or a computed write of the low byte. A decoder outside the block supplies the operation code, the address field of the instruction word and the byte for low-byte writes. The block returns the fetch address, a flush flag for the word already fetched, and a side-band strobe that loads the return literal into the working register.

Any change of flow costs two instruction cycles, because the word fetched behind the branch is thrown away. The flush flag marks that one discarded cycle, and the block ignores the operation code presented during it. Reset points the counter at the last implemented word, so the first sequential step rolls over to address 0. The implemented program space is a power-of-two parameter, and every address the block forms wraps modulo that size.

The return stack never reports overflow or underflow. A third nested call pushes the oldest return address off the bottom. Each return copies level 2 into level 1, so returns made beyond the stack depth keep reusing the bottom value.

Top module: `fetch_addr_seq`

## Requirements
- R1: While reset is high, and on the first cycle after it, fetch_addr equals MEM_WORDS-1 and flush is 0. The first sequential step after reset gives address 0.
- R2: In a cycle where adv is low, fetch_addr, flush and the stack contents do not change.
- R3: A sequential step (op code 0, or any unused code 5 to 7) sets fetch_addr to (fetch_addr+1) mod MEM_WORDS.
- R4: A jump (op code 1) loads all 9 bits of field, taken modulo MEM_WORDS.
- R5: A call (op code 2) loads {0, field[7:0]}, so bit 8 is always cleared. It pushes the current fetch_addr: level 1 moves down to level 2, and the pushed address becomes level 1.
- R6: A low-byte write (op code 4) loads {0, pcl_data} and leaves the stack unchanged.
- R7: A return (op code 3) loads level 1 into the counter and copies level 2 into level 1. In the same cycle it raises w_load, with w_data equal to field[7:0].
- R8: After three nested calls, returns go back only to the two most recent return addresses. Every further return goes to the bottom value again.
- R9: After any jump, call, return or low-byte write, flush is 1 for exactly one instruction cycle. In that cycle the op code is ignored: the step is sequential, the stack is left alone and w_load stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv | input | 1 | Instruction-cycle advance strobe |
| op | input | 3 | Decoded flow operation: 0 seq, 1 jump, 2 call, 3 return, 4 low-byte write |
| field | input | 9 | Address or literal field of the instruction word |
| pcl_data | input | 8 | Result byte for low-byte writes |
| fetch_addr | output | 9 | Address of the next word to fetch |
| flush | output | 1 | The word currently fetched is to be discarded |
| w_load | output | 1 | Load the return literal into the working register |
| w_data | output | 8 | Return literal |

## Verification
The hardest states to reach are at the limits of the stack: a third nested call that silently drops the oldest return address, followed by returns that run past the stack depth and keep landing on the bottom value. Each of these needs a long, ordered run of branches, and every branch is interleaved with a flush cycle. Directed sequences build those runs explicitly, and each flush cycle carries a conflicting op code to show that it is ignored. Seeded random stimulus then mixes every operation with idle cycles, and a bench model of the counter and the two stack levels checks the result.

// File: rtl/fas_pkg.sv
`timescale 1ns/1ps
package fas_pkg;
    localparam int FAS_PC_W  = 9;
    localparam int FAS_LIT_W = 8;

    typedef logic [FAS_PC_W-1:0]  pc_t;
    typedef logic [FAS_LIT_W-1:0] lit_t;

    typedef enum logic [2:0] {
        OP_SEQ  = 3'd0,
        OP_JUMP = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_PCLW = 3'd4
    } fas_op_e;

    typedef struct packed {
        logic load;   // flow change: target replaces the sequential address
        logic push;
        logic pop;
        logic wload;
        pc_t  target;
    } seq_ctl_t;

    function automatic pc_t low_byte_target(input lit_t b);
        return pc_t'(b);
    endfunction
endpackage

// File: rtl/fas_stack.sv
`timescale 1ns/1ps
module fas_stack
    import fas_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  pc_t  push_val,
    output pc_t  top
);
    pc_t lvl [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
            always_ff @(posedge clk) begin
                if (rst) begin
                    lvl[i] <= '0;
                end else if (push) begin
                    if (i == 0) lvl[i] <= push_val;
                    else        lvl[i] <= lvl[(i > 0) ? i-1 : 0];
                end else if (pop) begin
                    // bottom level keeps its value: repeated pops reuse it
                    if (i < DEPTH-1) lvl[i] <= lvl[(i < DEPTH-1) ? i+1 : i];
                end
            end
        end
    endgenerate

    assign top = lvl[0];
endmodule

// File: rtl/fas_next_pc.sv
`timescale 1ns/1ps
module fas_next_pc
    import fas_pkg::*;
#(
    parameter int MEM_WORDS = 512
) (
    input  logic       flushing,
    input  logic [2:0] op,
    input  pc_t        pc_q,
    input  pc_t        field,
    input  lit_t       pcl_data,
    input  pc_t        stk_top,
    output seq_ctl_t   ctl
);
    localparam pc_t ADDR_MASK = pc_t'(MEM_WORDS - 1);

    always_comb begin
        ctl        = '0;
        ctl.target = pc_t'(pc_q + 1'b1) & ADDR_MASK;
        if (!flushing) begin
            case (op)
                OP_JUMP: begin
                    ctl.load   = 1'b1;
                    ctl.target = field & ADDR_MASK;
                end
                OP_CALL: begin
                    ctl.load   = 1'b1;
                    ctl.push   = 1'b1;
                    ctl.target = low_byte_target(field[FAS_LIT_W-1:0]) & ADDR_MASK;
                end
                OP_RET: begin
                    ctl.load   = 1'b1;
                    ctl.pop    = 1'b1;
                    ctl.wload  = 1'b1;
                    ctl.target = stk_top;
                end
                OP_PCLW: begin
                    ctl.load   = 1'b1;
                    ctl.target = low_byte_target(pcl_data) & ADDR_MASK;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fetch_addr_seq.sv
`timescale 1ns/1ps
module fetch_addr_seq
    import fas_pkg::*;
#(
    parameter int MEM_WORDS = 512
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adv,
    input  logic [2:0]           op,
    input  logic [FAS_PC_W-1:0]  field,
    input  logic [FAS_LIT_W-1:0] pcl_data,
    output logic [FAS_PC_W-1:0]  fetch_addr,
    output logic                 flush,
    output logic                 w_load,
    output logic [FAS_LIT_W-1:0] w_data
);
    localparam pc_t LAST_WORD = pc_t'(MEM_WORDS - 1);

    pc_t      pc_q;
    logic     flush_q;
    pc_t      stk_top;
    seq_ctl_t ctl;

    fas_next_pc #(.MEM_WORDS(MEM_WORDS)) u_next (
        .flushing (flush_q),
        .op       (op),
        .pc_q     (pc_q),
        .field    (field),
        .pcl_data (pcl_data),
        .stk_top  (stk_top),
        .ctl      (ctl)
    );

    fas_stack #(.DEPTH(2)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (adv & ctl.push),
        .pop      (adv & ctl.pop),
        .push_val (pc_q),
        .top      (stk_top)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= LAST_WORD;
            flush_q <= 1'b0;
        end else if (adv) begin
            pc_q    <= ctl.target;
            flush_q <= ctl.load;
        end
    end

    assign fetch_addr = pc_q;
    assign flush      = flush_q;
    assign w_load     = adv & ctl.wload;
    assign w_data     = field[FAS_LIT_W-1:0];
endmodule

// File: rtl/fas_checker.sv
`timescale 1ns/1ps
module fas_checker
    import fas_pkg::*;
#(
    parameter int MEM_WORDS = 512
) (
    input logic       clk,
    input logic       rst,
    input logic       adv,
    input logic [2:0] op,
    input pc_t        field,
    input pc_t        fetch_addr,
    input logic       flush,
    input logic       w_load
);
    localparam pc_t MASK = pc_t'(MEM_WORDS - 1);

    assert_reset_vector_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fetch_addr == MASK) && !flush);

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(adv)) |-> $stable(fetch_addr) && $stable(flush));

    assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(adv) && $past(op) == 3'd0 && !$past(flush))
        |-> fetch_addr == (pc_t'($past(fetch_addr) + 1'b1) & MASK) && !flush);

    assert_jump_target_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(adv) && $past(op) == 3'd1 && !$past(flush))
        |-> fetch_addr == ($past(field) & MASK) && flush);

    assert_call_page_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(adv) && $past(op) == 3'd2 && !$past(flush))
        |-> !fetch_addr[FAS_PC_W-1] && flush);

    assert_flush_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        (flush && adv) |=> !flush);

    assert_literal_only_on_return_R7: assert property (@(posedge clk) disable iff (rst)
        w_load |-> adv && !flush && op == 3'd3);
endmodule

bind fetch_addr_seq fas_checker #(.MEM_WORDS(MEM_WORDS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .adv        (adv),
    .op         (op),
    .field      (field),
    .fetch_addr (fetch_addr),
    .flush      (flush),
    .w_load     (w_load)
);

// File: tb/tb_fetch_addr_seq.sv
`timescale 1ns/1ps
module tb_fetch_addr_seq;
    localparam int N = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adv = 1'b0;
    logic [2:0] op = 3'd0;
    logic [8:0] field = '0;
    logic [7:0] pcl_data = '0;
    logic [8:0] fetch_addr;
    logic       flush;
    logic       w_load;
    logic [7:0] w_data;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    int m_pc, m_s1, m_s2;
    bit m_fl;

    always #2.5 clk = ~clk;

    fetch_addr_seq #(.MEM_WORDS(N)) dut (
        .clk(clk), .rst(rst), .adv(adv), .op(op), .field(field),
        .pcl_data(pcl_data), .fetch_addr(fetch_addr), .flush(flush),
        .w_load(w_load), .w_data(w_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    function automatic string req_of(input int o, input bit fl, input bit a);
        if (!a) return "R2";
        if (fl) return "R9";
        case (o)
            1: return "R4";
            2: return "R5";
            3: return "R7";
            4: return "R6";
            default: return "R3";
        endcase
    endfunction

    // drive one cycle at a negedge, check results at the next negedge
    task automatic step(input bit a, input int o, input int f, input int p);
        string r;
        bit exp_wl;
        r = req_of(o, m_fl, a);
        adv = a; op = 3'(o); field = 9'(f); pcl_data = 8'(p);
        #1;
        exp_wl = a && !m_fl && (o == 3);
        chk(exp_wl ? "R7" : r, int'(w_load), int'(exp_wl));
        if (exp_wl) chk("R7", int'(w_data), f & 8'hFF);
        if (a) begin
            if (m_fl) begin
                m_pc = (m_pc + 1) % N; m_fl = 0;
            end else begin
                case (o)
                    1: begin m_pc = f % N; m_fl = 1; end
                    2: begin m_s2 = m_s1; m_s1 = m_pc; m_pc = (f & 8'hFF) % N; m_fl = 1; end
                    3: begin m_pc = m_s1; m_s1 = m_s2; m_fl = 1; end
                    4: begin m_pc = (p & 8'hFF) % N; m_fl = 1; end
                    default: m_pc = (m_pc + 1) % N;
                endcase
            end
        end
        @(negedge clk);
        chk(r, int'(fetch_addr), m_pc);
        chk(r, int'(flush), int'(m_fl));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_pc = N - 1; m_s1 = 0; m_s2 = 0; m_fl = 0;
        repeat (3) @(negedge clk);
        chk("R1", int'(fetch_addr), N - 1);   // during reset
        rst = 1'b0;
        @(negedge clk);
        chk("R1", int'(fetch_addr), N - 1);
        chk("R1", int'(flush), 0);
        step(1, 0, 0, 0);                      // R1 rollover to 0
        chk("R1", int'(fetch_addr), 0);
        step(1, 0, 0, 0);                      // R3
        step(0, 1, 9'h155, 0);                 // R2 idle: jump ignored
        // R5 call with bit 8 set in field; R9 flush cycle carries a jump
        step(1, 2, 9'h1A5, 0);
        chk("R5", int'(fetch_addr), 9'h0A5);
        step(1, 1, 9'h033, 0);
        chk("R9", int'(fetch_addr), 9'h0A6);
        // R8 three nested calls, each flush cycle carrying a return
        step(1, 2, 9'h010, 0); step(1, 3, 9'h0EE, 0);
        step(1, 2, 9'h020, 0); step(1, 3, 9'h0EE, 0);
        step(1, 2, 9'h030, 0); step(1, 0, 0, 0);
        step(0, 0, 0, 0);                      // R2 idle keeps stack
        // R8 three returns: two latest addresses, then bottom reused
        step(1, 3, 9'h05A, 0); chk("R8", int'(fetch_addr), 9'h021); step(1, 0, 0, 0);
        step(1, 3, 9'h0A5, 0); chk("R8", int'(fetch_addr), 9'h011); step(1, 0, 0, 0);
        step(1, 3, 9'h1FF, 0); chk("R8", int'(fetch_addr), 9'h011); step(1, 0, 0, 0);
        // R6 low-byte write, R4 full-width jump, unused op code as R3
        step(1, 4, 0, 8'hC3); chk("R6", int'(fetch_addr), 9'h0C3); step(1, 0, 0, 0);
        step(1, 1, 9'h1FF, 0); step(1, 0, 0, 0);
        chk("R3", int'(fetch_addr), 0);
        step(1, 6, 9'h123, 0);
        step(1, 3, 9'h077, 0); step(1, 0, 0, 0); // R6 left stack intact
        for (int i = 0; i < 4000; i++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            step(sel != 0, (sel < 4) ? 0 : int'($urandom_range(1, 7)),
                 int'($urandom_range(0, 511)), int'($urandom_range(0, 255)));
        end
        summary();
    end
endmodule